// File: doc/BRIEF.md
# I2C Byte Master Transmitter

This block drives an I2C bus as a master that only transmits, one byte at a time, under software control. Software places a byte in a single data register. For the first frame of a transfer that byte is the address: a 7-bit slave address with a direction bit of 0 (write) as its least significant bit. Software programs three counts in input-clock cycles: how long SCL stays low, how long it stays high, and how long after SCL falls SDA may change. A start pulse then puts a START condition on the bus, and the byte is shifted out MSB first. The acknowledge slot follows the eighth bit.

The block raises an interrupt flag after each byte's acknowledge slot and after an arbitration loss. It never raises the flag for the START condition or for a STOP. While the flag is set, a 2-bit status code describes the bus state. As long as the block still owns the bus, it also holds SCL low. Software answers with a status write. That write clears the flag and releases the stretch. The block then either sends the byte now in the data register, or performs a STOP if a stop request is pending. Both lines are open-drain: each has a drive-low enable output and a sampled line input.

The data register is loaded through a valid/ready port. `tx_ready` is high only while no bits are on the wire: in idle, and while the block waits with its flag set. A byte is captured on each clock edge where `tx_valid` and `tx_ready` are both high, and the last byte captured is the one sent. While a byte is shifting, `tx_ready` is low, so the source must hold its byte, and an offered byte is not taken.

Top module: `i2cm_byte_tx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `irq` and `busy` are 0, `status` is 0 (none), and `tx_ready` is 1.
- R2: `tx_ready` is 1 only in idle or while waiting with the flag set. A byte is captured only when `tx_valid` and `tx_ready` are both high. A byte offered while `tx_ready` is 0 is not taken, and the register keeps its previous byte.
- R3: A `start_req` pulse in idle with the flag clear pulls SDA low while SCL stays released, for `cfg_scl_hi` counted cycles, and then pulls SCL low. No interrupt is raised for the START.
- R4: Within a byte, SCL is driven low for exactly `cfg_scl_lo` cycles and released for exactly `cfg_scl_hi` cycles. High cycles are counted only while `scl_in` reads 1.
- R5: In every low phase, SDA changes exactly `cfg_sda_hold` cycles after SCL is pulled low, with 1 ≤ hold < low count. SDA never changes during a bit's high phase.
- R6: The data byte goes out MSB first. A 0 bit drives SDA low (`sda_oe`=1) and a 1 bit releases it. In the ninth (acknowledge) bit, SDA is released.
- R7: In the last high cycle of the ninth SCL pulse, `sda_in` is sampled. The flag is then raised whether or not the slave acknowledged, with status 1 (ACK) if SDA read 0 and status 2 (NACK) if it read 1.
- R8: While the flag is set and the block is busy, SCL stays driven low.
- R9: A `stat_wr` pulse clears the flag and sets the status to 0. If no stop is pending, the block then sends the byte held in the data register, starting a new low phase.
- R10: A `stop_req` pulse made while busy is remembered. At the next `stat_wr`, the block performs a STOP: it pulls SDA low during a low phase, releases SCL for the high count, then releases SDA while SCL is high. It returns to idle with no interrupt.
- R11: If SDA reads 0 at the sample point of a data bit in which the block released SDA, the block sets status 3 (arbitration lost) and raises the flag. On that same edge it releases both lines and goes idle, and the rest of the byte is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scl_lo | input | CNT_W | SCL low period in clocks |
| cfg_scl_hi | input | CNT_W | SCL high period in clocks |
| cfg_sda_hold | input | CNT_W | Clocks from SCL fall to SDA change |
| tx_data | input | BYTE_W | Byte offered to the data register |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Data register can take a byte |
| start_req | input | 1 | Pulse: begin transfer with START |
| stop_req | input | 1 | Pulse: end transfer with STOP at next status write |
| stat_wr | input | 1 | Pulse: status write, clears flag and resumes |
| irq | output | 1 | Interrupt flag |
| status | output | 2 | 0 none, 1 ACK, 2 NACK, 3 arbitration lost |
| busy | output | 1 | Block owns the bus |
| scl_oe | output | 1 | Drive SCL low |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | Drive SDA low |
| sda_in | input | 1 | Sampled SDA line |

## Verification
An error in the bit index or the data-register select shows up as a wrong byte at the bus decoder once that byte's eighth rising SCL edge has passed. A fault in the phase counter or the hold compare shows up as a low period, high period or SDA change point that is off by at least one clock, which is seen within the first bit after START. A fault in the flag or in the wait state shows up as SCL released while the flag is set, a missing code, or a lost STOP. Any of these is visible within a few cycles of the acknowledge slot. A fault in the arbitration path shows up as a byte that keeps shifting after a rival has pulled SDA low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_ACK  = 2'd1,
    CODE_NACK = 2'd2,
    CODE_LOST = 2'd3
  } i2cm_code_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_WAIT,
    PH_STOP_LO,
    PH_STOP_HI
  } i2cm_phase_e;

endpackage

// File: rtl/i2cm_phase_cnt.sv
module i2cm_phase_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         advance,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] mark,
  output logic         done,
  output logic         at_mark
);
  logic [W-1:0] cnt_q;

  assign done    = advance && (cnt_q == limit - 1'b1);
  assign at_mark = advance && (cnt_q == mark - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || done)  cnt_q <= '0;
    else if (advance)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cm_tx_shreg.sv
module i2cm_tx_shreg #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              in_ready,
  output logic              cur_bit
);
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W:0]   order_v;

  assign in_ready = accept_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   data_q <= '0;
    else if (in_valid && in_ready) data_q <= in_data;
  end

  // wire order: MSB first, then the acknowledge slot as a released bit
  for (genvar i = 0; i < BYTE_W; i++) begin : g_order
    assign order_v[i] = data_q[BYTE_W-1-i];
  end
  assign order_v[BYTE_W] = 1'b1;

  assign cur_bit = order_v[bit_idx];
endmodule

// File: rtl/i2cm_flag.sv
module i2cm_flag
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raise,
  input  i2cm_code_e raise_code,
  input  logic       clear,
  output logic       irq,
  output i2cm_code_e code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      code <= CODE_NONE;
    end else if (raise) begin
      irq  <= 1'b1;
      code <= raise_code;
    end else if (clear) begin
      irq  <= 1'b0;
      code <= CODE_NONE;
    end
  end
endmodule

// File: rtl/i2cm_byte_tx.sv
module i2cm_byte_tx
  import i2cm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_scl_lo,
  input  logic [CNT_W-1:0]  cfg_scl_hi,
  input  logic [CNT_W-1:0]  cfg_sda_hold,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              stat_wr,
  output logic              irq,
  output logic [1:0]        status,
  output logic              busy,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  i2cm_phase_e      phase_q;
  logic [IDX_W-1:0] bit_idx_q;
  logic             sda_oe_q;
  logic             stop_pend_q;

  logic             high_phase;
  logic [CNT_W-1:0] limit;
  logic             cnt_restart, cnt_adv, ph_done, ph_mark;
  logic             cur_bit, is_ack, lost, start_go, stop_go;
  logic             raise;
  i2cm_code_e       raise_code, code;

  assign high_phase  = (phase_q == PH_START) || (phase_q == PH_BIT_HI) ||
                       (phase_q == PH_STOP_HI);
  assign limit       = high_phase ? cfg_scl_hi : cfg_scl_lo;
  assign cnt_restart = (phase_q == PH_IDLE) || (phase_q == PH_WAIT);
  assign cnt_adv     = high_phase ? scl_in : 1'b1;

  i2cm_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cnt_restart),
    .advance (cnt_adv),
    .limit   (limit),
    .mark    (cfg_sda_hold),
    .done    (ph_done),
    .at_mark (ph_mark)
  );

  i2cm_tx_shreg #(.BYTE_W(BYTE_W)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en ((phase_q == PH_IDLE) || (phase_q == PH_WAIT)),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .bit_idx   (bit_idx_q),
    .in_ready  (tx_ready),
    .cur_bit   (cur_bit)
  );

  assign is_ack   = (bit_idx_q == ACK_IDX);
  assign lost     = (phase_q == PH_BIT_HI) && ph_done && !is_ack &&
                    !sda_oe_q && !sda_in;
  assign start_go = (phase_q == PH_IDLE) && start_req && !irq;
  assign stop_go  = (phase_q == PH_WAIT) && stat_wr && stop_pend_q;

  assign raise      = lost || ((phase_q == PH_BIT_HI) && ph_done && is_ack);
  assign raise_code = lost ? CODE_LOST : (sda_in ? CODE_NACK : CODE_ACK);

  i2cm_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise      (raise),
    .raise_code (raise_code),
    .clear      (stat_wr),
    .irq        (irq),
    .code       (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    stop_pend_q <= 1'b0;
    else if (stop_go)              stop_pend_q <= 1'b0;
    else if (phase_q == PH_IDLE)   stop_pend_q <= 1'b0;
    else if (stop_req)             stop_pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bit_idx_q <= '0;
      sda_oe_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_go) begin
          phase_q   <= PH_START;
          sda_oe_q  <= 1'b1;
          bit_idx_q <= '0;
        end
        PH_START: if (ph_done) phase_q <= PH_BIT_LO;
        PH_BIT_LO: begin
          if (ph_mark) sda_oe_q <= ~cur_bit;
          if (ph_done) phase_q  <= PH_BIT_HI;
        end
        PH_BIT_HI: if (ph_done) begin
          if (lost) begin
            phase_q  <= PH_IDLE;
            sda_oe_q <= 1'b0;
          end else if (is_ack) begin
            phase_q  <= PH_WAIT;
          end else begin
            bit_idx_q <= bit_idx_q + 1'b1;
            phase_q   <= PH_BIT_LO;
          end
        end
        PH_WAIT: if (stat_wr) begin
          if (stop_pend_q) phase_q <= PH_STOP_LO;
          else begin
            phase_q   <= PH_BIT_LO;
            bit_idx_q <= '0;
          end
        end
        PH_STOP_LO: begin
          if (ph_mark) sda_oe_q <= 1'b1;
          if (ph_done) phase_q  <= PH_STOP_HI;
        end
        PH_STOP_HI: if (ph_done) begin
          sda_oe_q <= 1'b0;
          phase_q  <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe = (phase_q == PH_BIT_LO) || (phase_q == PH_WAIT) ||
                  (phase_q == PH_STOP_LO);
  assign sda_oe = sda_oe_q;
  assign busy   = (phase_q != PH_IDLE);
  assign status = code;
endmodule

// File: rtl/i2cm_byte_tx_chk.sv
module i2cm_byte_tx_chk
  import i2cm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic [1:0]  status,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        stat_wr,
  input i2cm_phase_e phase
);
  // R8
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && busy) |-> scl_oe);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && stat_wr) |=> !irq);

  // R3
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !irq);

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIT_HI && $past(phase) == PH_BIT_HI) |-> $stable(sda_oe));

  // R11
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status == 2'd3) |-> (!busy && !scl_oe && !sda_oe));

  // R7
  code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status != 2'd0));
endmodule

bind i2cm_byte_tx i2cm_byte_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .irq     (irq),
  .status  (status),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .stat_wr (stat_wr),
  .phase   (phase_q)
);

// File: tb/i2cm_byte_tx_tb_top.sv
module i2cm_byte_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] cfg_lo = 16'd6, cfg_hi = 16'd5, cfg_hold = 16'd3;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 0, start_req = 0, stop_req = 0, stat_wr = 0;
  logic        tx_ready, irq, busy, scl_oe, sda_oe;
  logic [1:0]  status;
  logic        slave_low = 0, rival_low = 0, ack_en = 1;
  logic        scl_in, sda_in;

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | slave_low | rival_low);

  i2cm_byte_tx dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_scl_lo(cfg_lo), .cfg_scl_hi(cfg_hi), .cfg_sda_hold(cfg_hold),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .start_req(start_req), .stop_req(stop_req), .stat_wr(stat_wr),
    .irq(irq), .status(status), .busy(busy),
    .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus monitor, slave model and scoreboard
  logic p_scl = 1, p_sda = 1, p_scl_oe = 0, p_sda_oe = 0, p_busy = 0;
  logic low_irq = 0;
  int bitn = 0, stop_cnt = 0, lowcnt = 0, hicnt = 0;
  logic [7:0] shift_v = '0, exp_b;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_in && p_scl && p_sda && !sda_in) begin bitn = 0; shift_v = '0; end
      if (scl_in && p_scl && !p_sda && sda_in) stop_cnt++;
      if (scl_in && !p_scl) begin
        if (bitn < 8) begin
          shift_v = {shift_v[6:0], sda_in};
          bitn++;
          if (bitn == 8) begin
            if (exp_q.size() == 0) check(0, "R6 unexpected byte", shift_v, 0);
            else begin
              exp_b = exp_q.pop_front();
              check(shift_v == exp_b, "R6 byte", shift_v, exp_b);
            end
          end
        end else if (bitn == 8) begin
          check(!sda_oe, "R6 ack slot released", sda_oe, 0);
          bitn = 9;
        end
      end
      if (!scl_in && p_scl) begin
        if (bitn == 8) slave_low = ack_en;
        else if (bitn == 9) begin slave_low = 0; bitn = 0; end
      end
      if (scl_oe) begin
        if (!p_scl_oe) begin
          if (hicnt > 0) check(hicnt == int'(cfg_hi), "R4 high period", hicnt, cfg_hi);
          hicnt = 0; lowcnt = 1; low_irq = irq;
        end else begin
          lowcnt++; low_irq = low_irq | irq;
        end
        if (sda_oe != p_sda_oe && !low_irq)
          check(lowcnt == int'(cfg_hold) + 1, "R5 hold point", lowcnt - 1, cfg_hold);
      end else begin
        if (p_scl_oe && !low_irq) check(lowcnt == int'(cfg_lo), "R4 low period", lowcnt, cfg_lo);
        if (busy) hicnt++; else hicnt = 0;
        if (busy && p_busy && !p_scl_oe && sda_oe != p_sda_oe)
          check(0, "R5 SDA moved while SCL high", sda_oe, p_sda_oe);
      end
    end
    p_scl = scl_in; p_sda = sda_in; p_scl_oe = scl_oe; p_sda_oe = sda_oe; p_busy = busy;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offers a byte and queues it as expected on the wire
  task automatic load(input logic [7:0] b, input bit expect_on_wire);
    @(negedge clk);
    check(tx_ready, "R2 ready before load", tx_ready, 1);
    tx_valid = 1; tx_data = b;
    @(negedge clk);
    tx_valid = 0;
    if (expect_on_wire) exp_q.push_back(b);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1; @(negedge clk); start_req = 0;
  endtask
  task automatic pulse_stat();
    @(negedge clk); stat_wr = 1; @(negedge clk); stat_wr = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
  endtask
  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic finish_stop();
    int sc;
    sc = stop_cnt;
    pulse_stop();
    pulse_stat();
    while (busy) @(negedge clk);
    tick(1);
    check(stop_cnt == sc + 1, "R10 stop seen", stop_cnt - sc, 1);
    check(!irq && !scl_oe && !sda_oe, "R10 idle, no flag", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic one_byte(input logic [7:0] b);
    load(b, 1);
    pulse_start();
    wait_irq();
    check(status == 2'd1, "R7 ack", status, 1);
    finish_stop();
  endtask

  initial begin
    tick(3);
    check(!scl_oe && !sda_oe && !irq && !busy && status == 0 && tx_ready,
          "R1 reset state", {scl_oe, sda_oe, irq, busy, status, tx_ready}, 1);
    rst_n = 1;
    tick(2);

    // address byte, two data bytes, then stop
    load(8'hA4, 1);
    pulse_start();
    check(busy && sda_oe && !scl_oe && !irq, "R3 start condition",
          {busy, sda_oe, scl_oe, irq}, 4'b1100);
    while (!scl_oe) @(negedge clk);
    check(!irq, "R3 no flag for start", irq, 0);
    wait_irq();
    check(status == 2'd1, "R7 ack on address", status, 1);
    check(tx_ready, "R2 ready while waiting", tx_ready, 1);
    begin
      bit held = 1;
      for (int k = 0; k < 15; k++) begin
        if (!(scl_oe && irq && busy)) held = 0;
        @(negedge clk);
      end
      check(held, "R8 SCL stretched while flag set", held, 1);
    end
    load(8'h5B, 1);
    pulse_stat();
    check(!irq && status == 0, "R9 flag cleared", {irq, status}, 0);
    tick(4);
    check(!tx_ready, "R2 not ready while shifting", tx_ready, 0);
    wait_irq();
    check(status == 2'd1, "R7 ack on data", status, 1);

    ack_en = 0;
    load(8'hC3, 1);
    pulse_stat();
    wait_irq();
    check(status == 2'd2, "R7 nack still flags", status, 2);
    ack_en = 1;

    // no load: register content is resent; a byte offered mid-shift is not taken
    exp_q.push_back(8'hC3);
    pulse_stat();
    tick(5);
    tx_valid = 1; tx_data = 8'hEE;
    @(negedge clk);
    tx_valid = 0;
    wait_irq();
    check(status == 2'd1, "R9 resend ack", status, 1);
    exp_q.push_back(8'hC3);
    pulse_stat();
    wait_irq();
    check(status == 2'd1, "R2 offered byte ignored", status, 1);
    finish_stop();

    // other timings, including hold at both ends of its range
    cfg_lo = 16'd9; cfg_hi = 16'd3; cfg_hold = 16'd8;
    one_byte(8'h81);
    cfg_lo = 16'd4; cfg_hi = 16'd7; cfg_hold = 16'd1;
    one_byte(8'h7E);

    // arbitration loss on the third bit of 0x3C
    cfg_lo = 16'd6; cfg_hi = 16'd4; cfg_hold = 16'd2;
    load(8'h3C, 0);
    pulse_start();
    while (!scl_oe) @(negedge clk);
    rival_low = 1;
    wait_irq();
    check(status == 2'd3, "R11 lost code", status, 3);
    check(!busy && !scl_oe && !sda_oe, "R11 lines released", {busy, scl_oe, sda_oe}, 0);
    check(bitn == 3, "R11 stopped at lost bit", bitn, 3);
    tick(6);
    check(!scl_oe && !busy, "R11 stays idle", {scl_oe, busy}, 0);
    rival_low = 0;
    pulse_stat();
    check(!irq && status == 0, "R9 lost flag cleared", {irq, status}, 0);

    one_byte(8'hA5);
    check(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule